// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break and Activity Status

This block is the receive front end of an asynchronous serial port. A one-cycle pulse on `os_tick` marks each oversample instant, and there are sixteen of these per bit time. The block looks for start bits on the line. It assembles characters of eight data bits, or of nine when `nine_mode` is high, sending the least significant bit first. It captures each finished character into a data register, and a reset does not touch that register.

Four status flags sit beside the data register. The first is a break flag, which reports a frame that is entirely low. The second is an activity flag, which rises at the first low sample of a start search. The third is a framing-error flag, and the fourth is a data-ready flag. The flags are read-only. They raise no interrupt. Software clears them by reading the status register and then the data register. Software issues register reads as one-cycle strobes: `stat_rd` for the status register, `data_rd` for the data register, and `other_rd` for any other register of the port.

Top module: `uart_rx_status`

## Requirements
- R1: A frame in which the start bit, every data bit (including the ninth in 9-bit mode) and the stop bit all sample as 0 is a break. It sets `brk_flag`, `fe_flag` and `rdf_flag`, and it loads 0 into `rx_data`. A frame of data 0x00 with a stop bit of 1 is not a break.
- R2: In 9-bit mode a break forces `rx_bit8` to 0, whatever the previous character left there. In 8-bit mode `rx_bit8` reads 0.
- R3: `brk_flag` clears only through a specific sequence. First, a `stat_rd` strobe must arrive while the flag is set. Next, a `data_rd` strobe must follow. Any `other_rd` between the two reads cancels the sequence. A `data_rd` with no armed `stat_rd` before it changes nothing.
- R4: Once `brk_flag` has been cleared, holding the line low does not set it again. It sets again only after the line has sampled 1 and a new break frame has arrived.
- R5: `rxip_flag` goes to 1 one cycle after the tick on which the receiver, while searching for a start, samples a 0. That tick is RT1.
- R6: `rxip_flag` returns to 0 in two cases. One case is a false start, where at least two of the three start-bit samples taken at RT3, RT5 and RT7 are 1. The other case is an idle line, meaning a full character time of 1 samples: 160 ticks in 8-bit mode and 176 ticks in 9-bit mode.
- R7: The receiver decides each data bit by majority vote over its samples at RT8, RT9 and RT10. A single deviating sample at RT9 therefore has no effect. Each completed frame loads `rx_data` and `rx_bit8` and sets `rdf_flag`.
- R8: `fe_flag` sets when the voted stop bit is 0. A frame with a stop bit of 1 leaves `fe_flag` clear.
- R9: Reset clears all four flags and leaves `rx_data` holding the last received character.
- R10: `fe_flag` and `rdf_flag` follow the same clear rule as R3. A `stat_rd` arms the flags that are set at that moment. The next `data_rd` clears them, unless an `other_rd` comes in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle oversample pulse, 16 per bit |
| rxd | input | 1 | Serial receive line, idle high |
| nine_mode | input | 1 | 1 selects 9-bit characters |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| other_rd | input | 1 | Strobe for an access to any other register |
| brk_flag | output | 1 | Break detected |
| rxip_flag | output | 1 | Reception in progress |
| fe_flag | output | 1 | Framing error |
| rdf_flag | output | 1 | Received data ready |
| rx_data | output | 8 | Received data bits |
| rx_bit8 | output | 1 | Received ninth bit |

## Verification
`rxd` passes through a two-stage synchronizer, so each tick acts on the line value driven three clocks before that tick. The bench drives each line value three clocks ahead of its tick. The block reports frame results one clock after the RT10 tick of the stop bit. `rxip_flag` changes one clock after the tick that sets or clears it. A read strobe changes the flags one clock after the strobe. The bench compares only after the last tick of a frame or of a tick run, plus one settling clock, and after each strobe has returned low. At those points every result is already final.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_HUNT  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx,
  input  logic              nine_mode,
  output logic              start_evt,
  output logic              false_evt,
  output logic              idle_evt,
  output logic              one_evt,
  output logic              char_evt,
  output logic              char_stop,
  output logic              char_zero,
  output logic [DATA_W-1:0] char_data,
  output logic              char_b8
);
  localparam int CW = $clog2(OSR + 1);
  localparam int IW = $clog2(OSR * (DATA_W + 3) + 1);
  localparam int BW = $clog2(DATA_W + 2);
  localparam logic [CW-1:0] RT_S1  = CW'(3);
  localparam logic [CW-1:0] RT_S2  = CW'(5);
  localparam logic [CW-1:0] RT_S3  = CW'(7);
  localparam logic [CW-1:0] RT_D1  = CW'(OSR / 2);
  localparam logic [CW-1:0] RT_D2  = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] RT_D3  = CW'(OSR / 2 + 2);
  localparam logic [CW-1:0] RT_END = CW'(OSR);
  localparam logic [IW-1:0] IDLE_8 = IW'(OSR * (DATA_W + 2));
  localparam logic [IW-1:0] IDLE_9 = IW'(OSR * (DATA_W + 3));

  rx_state_e         state;
  logic [CW-1:0]     cnt, cur;
  logic [BW-1:0]     bitn, last_bit;
  logic [IW-1:0]     idle_cnt, idle_lim;
  logic              va, vb, maj, allz, wait_hi, b8;
  logic [DATA_W-1:0] shreg;

  always_comb begin
    cur      = (cnt == RT_END) ? CW'(1) : cnt + CW'(1);
    maj      = vote3(va, vb, rx);
    idle_lim = nine_mode ? IDLE_9 : IDLE_8;
    last_bit = nine_mode ? BW'(DATA_W) : BW'(DATA_W - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_HUNT;
      cnt       <= '0;
      bitn      <= '0;
      va        <= 1'b0;
      vb        <= 1'b0;
      shreg     <= '0;
      b8        <= 1'b0;
      allz      <= 1'b1;
      wait_hi   <= 1'b1;
      idle_cnt  <= '0;
      start_evt <= 1'b0;
      false_evt <= 1'b0;
      idle_evt  <= 1'b0;
      one_evt   <= 1'b0;
      char_evt  <= 1'b0;
      char_stop <= 1'b1;
      char_zero <= 1'b0;
    end else begin
      start_evt <= 1'b0;
      false_evt <= 1'b0;
      idle_evt  <= 1'b0;
      char_evt  <= 1'b0;
      one_evt   <= tick & rx;
      if (tick) begin
        case (state)
          RX_HUNT: begin
            if (rx) begin
              wait_hi <= 1'b0;
              if (idle_cnt < idle_lim) begin
                idle_cnt <= idle_cnt + IW'(1);
                if (idle_cnt == idle_lim - IW'(1)) idle_evt <= 1'b1;
              end
            end else begin
              idle_cnt <= '0;
              if (!wait_hi) begin
                state     <= RX_START;
                cnt       <= CW'(1);
                start_evt <= 1'b1;
                allz      <= 1'b1;
                b8        <= 1'b0;
              end
            end
          end
          RX_START: begin
            cnt <= cur;
            if (cur == RT_S1) va <= rx;
            if (cur == RT_S2) vb <= rx;
            if (cur == RT_S3 && maj) begin
              false_evt <= 1'b1;
              state     <= RX_HUNT;
            end else if (cur == RT_END) begin
              state <= RX_DATA;
              bitn  <= '0;
            end
          end
          RX_DATA: begin
            cnt <= cur;
            if (cur == RT_D1) va <= rx;
            if (cur == RT_D2) vb <= rx;
            if (cur == RT_D3) begin
              if (bitn < BW'(DATA_W)) shreg <= {maj, shreg[DATA_W-1:1]};
              else                    b8    <= maj;
              allz <= allz & ~maj;
            end
            if (cur == RT_END) begin
              if (bitn == last_bit) state <= RX_STOP;
              else                  bitn  <= bitn + BW'(1);
            end
          end
          RX_STOP: begin
            cnt <= cur;
            if (cur == RT_D1) va <= rx;
            if (cur == RT_D2) vb <= rx;
            if (cur == RT_D3) begin
              char_evt  <= 1'b1;
              char_stop <= maj;
              char_zero <= allz & ~maj;
              wait_hi   <= ~maj;
              idle_cnt  <= '0;
              state     <= RX_HUNT;
            end
          end
          default: state <= RX_HUNT;
        endcase
      end
    end
  end

  assign char_data = shreg;
  assign char_b8   = b8;

  p_one_event_r6: assert property (@(posedge clk) disable iff (rst)
    $countones({start_evt, false_evt, idle_evt, char_evt}) <= 1);
  p_char_from_stop_r7: assert property (@(posedge clk) disable iff (rst)
    char_evt |-> $past(state) == RX_STOP && state == RX_HUNT);
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nine_mode,
  input  logic              start_evt,
  input  logic              false_evt,
  input  logic              idle_evt,
  input  logic              one_evt,
  input  logic              char_evt,
  input  logic              char_stop,
  input  logic              char_zero,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_b8,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              other_rd,
  output logic              brk_flag,
  output logic              rxip_flag,
  output logic              fe_flag,
  output logic              rdf_flag,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8
);
  logic [2:0] arm, clr;
  logic       rearm, brk_det;

  always_comb begin
    brk_det = char_evt & char_zero & rearm;
    clr     = data_rd ? arm : 3'b000;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_flag  <= 1'b0;
      rxip_flag <= 1'b0;
      fe_flag   <= 1'b0;
      rdf_flag  <= 1'b0;
      arm       <= 3'b000;
      rearm     <= 1'b1;
    end else begin
      brk_flag <= (brk_flag & ~clr[2]) | brk_det;
      fe_flag  <= (fe_flag  & ~clr[1]) | (char_evt & ~char_stop);
      rdf_flag <= (rdf_flag & ~clr[0]) | char_evt;
      if (start_evt)                  rxip_flag <= 1'b1;
      else if (false_evt || idle_evt) rxip_flag <= 1'b0;
      if (stat_rd)                    arm <= {brk_flag, fe_flag, rdf_flag};
      else if (data_rd || other_rd)   arm <= 3'b000;
      if (brk_det)                    rearm <= 1'b0;
      else if (one_evt && !brk_flag)  rearm <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (char_evt) begin
      rx_data <= char_data;
      rx_bit8 <= nine_mode & char_b8 & ~char_zero;
    end
  end

  p_brk_side_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_flag) |-> fe_flag && rdf_flag);
  p_b8_break_r2: assert property (@(posedge clk) disable iff (rst)
    (char_evt && char_zero) |=> !rx_bit8);
  p_brk_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(brk_flag) |-> $past(data_rd));
  p_rxip_set_r5: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> rxip_flag);
  p_rxip_fall_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rxip_flag) |-> $past(false_evt || idle_evt));
  p_rdf_set_r7: assert property (@(posedge clk) disable iff (rst)
    char_evt |=> rdf_flag);
  p_fe_fall_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(fe_flag) |-> $past(data_rd));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              nine_mode,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              other_rd,
  output logic              brk_flag,
  output logic              rxip_flag,
  output logic              fe_flag,
  output logic              rdf_flag,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8
);
  logic              rx_s;
  logic              start_evt, false_evt, idle_evt, one_evt;
  logic              char_evt, char_stop, char_zero, char_b8;
  logic [DATA_W-1:0] char_data;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(rxd), .q(rx_s)
  );

  uart_rx_framer #(.OSR(OSR), .DATA_W(DATA_W)) framer_i (
    .clk(clk), .rst(rst), .tick(os_tick), .rx(rx_s), .nine_mode(nine_mode),
    .start_evt(start_evt), .false_evt(false_evt), .idle_evt(idle_evt),
    .one_evt(one_evt), .char_evt(char_evt), .char_stop(char_stop),
    .char_zero(char_zero), .char_data(char_data), .char_b8(char_b8)
  );

  uart_rx_flags #(.DATA_W(DATA_W)) flags_i (
    .clk(clk), .rst(rst), .nine_mode(nine_mode),
    .start_evt(start_evt), .false_evt(false_evt), .idle_evt(idle_evt),
    .one_evt(one_evt), .char_evt(char_evt), .char_stop(char_stop),
    .char_zero(char_zero), .char_data(char_data), .char_b8(char_b8),
    .stat_rd(stat_rd), .data_rd(data_rd), .other_rd(other_rd),
    .brk_flag(brk_flag), .rxip_flag(rxip_flag), .fe_flag(fe_flag),
    .rdf_flag(rdf_flag), .rx_data(rx_data), .rx_bit8(rx_bit8)
  );
endmodule

// File: tb/uart_rx_status_tb.sv
module uart_rx_status_tb_top;
  localparam int OSR = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic os_tick = 1'b0, rxd = 1'b1, nine_mode = 1'b0;
  logic stat_rd = 1'b0, data_rd = 1'b0, other_rd = 1'b0;
  logic brk_flag, rxip_flag, fe_flag, rdf_flag, rx_bit8;
  logic [7:0] rx_data;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_status dut_i (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd), .nine_mode(nine_mode),
    .stat_rd(stat_rd), .data_rd(data_rd), .other_rd(other_rd),
    .brk_flag(brk_flag), .rxip_flag(rxip_flag), .fe_flag(fe_flag),
    .rdf_flag(rdf_flag), .rx_data(rx_data), .rx_bit8(rx_bit8)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tk(input logic v);
    rxd = v;
    @(negedge clk);
    @(negedge clk);
    os_tick = 1'b1;
    @(negedge clk);
    os_tick = 1'b0;
  endtask

  task automatic run(input logic v, input int n);
    for (int i = 0; i < n; i++) tk(v);
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] d, input logic nine,
                            input logic stopv, input logic glitch);
    for (int t = 0; t < OSR; t++) tk(1'b0);
    for (int b = 0; b < (nine ? 9 : 8); b++)
      for (int t = 0; t < OSR; t++) tk((glitch && t == OSR / 2) ? ~d[b] : d[b]);
    for (int t = 0; t < OSR; t++) tk(stopv);
    @(negedge clk);
  endtask

  task automatic strobe(input int which);
    if (which == 0) stat_rd = 1'b1;
    else if (which == 1) data_rd = 1'b1;
    else other_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0; data_rd = 1'b0; other_rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset brk", brk_flag, 0);
    chk("R9 reset rxip", rxip_flag, 0);
    chk("R9 reset fe", fe_flag, 0);
    chk("R9 reset rdf", rdf_flag, 0);
    run(1'b1, 20);

    // R7 / R8 / R10 sweep in 8-bit mode
    for (int i = 0; i < 64; i++) begin
      logic [7:0] d;
      d = 8'((i * 37 + 11) & 255);
      if (i == 0) d = 8'h00;
      send_frame({1'b0, d}, 1'b0, 1'b1, 1'b0);
      chk("R7 data 8-bit", rx_data, d);
      chk("R7 rdf set", rdf_flag, 1);
      chk("R8 no fe with good stop", fe_flag, 0);
      chk("R1 no break on good stop", brk_flag, 0);
      chk("R2 ninth bit 0 in 8-bit mode", rx_bit8, 0);
      strobe(0); strobe(1);
      chk("R10 rdf cleared", rdf_flag, 0);
    end

    // R5 / R6 idle
    send_frame(9'h0C3, 1'b0, 1'b1, 1'b0);
    chk("R5 rxip after frame", rxip_flag, 1);
    run(1'b1, 150);
    chk("R6 rxip held before idle time", rxip_flag, 1);
    run(1'b1, 20);
    chk("R6 rxip cleared by idle", rxip_flag, 0);
    strobe(0); strobe(1);

    // R5 / R6 false start
    run(1'b0, 2);
    chk("R5 rxip on RT1 zero", rxip_flag, 1);
    run(1'b1, 20);
    chk("R6 rxip cleared by false start", rxip_flag, 0);
    chk("R6 false start gives no data", rdf_flag, 0);

    // R7 majority vote with RT9 glitch
    send_frame(9'h03C, 1'b0, 1'b1, 1'b1);
    chk("R7 glitch rejected", rx_data, 8'h3C);
    strobe(0); strobe(1);

    // R8 framing error
    send_frame(9'h05A, 1'b0, 1'b0, 1'b0);
    chk("R8 fe set", fe_flag, 1);
    chk("R1 nonzero data not break", brk_flag, 0);
    chk("R8 data still loaded", rx_data, 8'h5A);
    run(1'b1, 20);
    strobe(0); strobe(1);
    chk("R10 fe cleared", fe_flag, 0);

    // R10 clear sequence on rdf
    send_frame(9'h081, 1'b0, 1'b1, 1'b0);
    strobe(1);
    chk("R10 data read alone keeps rdf", rdf_flag, 1);
    strobe(0); strobe(2); strobe(1);
    chk("R10 other access cancels", rdf_flag, 1);
    strobe(0); strobe(1);
    chk("R10 sequence clears rdf", rdf_flag, 0);

    // R1 / R3 / R4 break in 8-bit mode
    send_frame(9'h000, 1'b0, 1'b0, 1'b0);
    chk("R1 brk set", brk_flag, 1);
    chk("R1 fe set", fe_flag, 1);
    chk("R1 rdf set", rdf_flag, 1);
    chk("R1 data zero", rx_data, 0);
    run(1'b0, 40);
    strobe(1);
    chk("R3 data read alone keeps brk", brk_flag, 1);
    strobe(0); strobe(2); strobe(1);
    chk("R3 other access cancels", brk_flag, 1);
    strobe(0); strobe(1);
    chk("R3 sequence clears brk", brk_flag, 0);
    chk("R10 sequence clears fe", fe_flag, 0);
    run(1'b0, 200);
    chk("R4 held low no new brk", brk_flag, 0);
    chk("R4 held low no new rdf", rdf_flag, 0);
    run(1'b1, 20);
    send_frame(9'h000, 1'b0, 1'b0, 1'b0);
    chk("R4 new break after ones", brk_flag, 1);
    run(1'b1, 20);
    strobe(0); strobe(1);
    chk("R3 cleared again", brk_flag, 0);

    // R7 sweep in 9-bit mode
    nine_mode = 1'b1;
    run(1'b1, 5);
    for (int i = 0; i < 32; i++) begin
      logic [8:0] d9;
      d9 = 9'((i * 83 + 5) & 511);
      send_frame(d9, 1'b1, 1'b1, 1'b0);
      chk("R7 data 9-bit low", rx_data, d9[7:0]);
      chk("R7 ninth bit", rx_bit8, d9[8]);
      strobe(0); strobe(1);
    end

    // R2 break clears ninth bit
    send_frame(9'h1FF, 1'b1, 1'b1, 1'b0);
    chk("R7 ninth bit set", rx_bit8, 1);
    strobe(0); strobe(1);
    send_frame(9'h000, 1'b1, 1'b0, 1'b0);
    chk("R2 break clears ninth bit", rx_bit8, 0);
    chk("R1 brk set 9-bit", brk_flag, 1);
    run(1'b1, 20);
    strobe(0); strobe(1);

    // R9 reset keeps data
    nine_mode = 1'b0;
    run(1'b1, 5);
    send_frame(9'h0A5, 1'b0, 1'b0, 1'b0);
    run(1'b0, 3);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 data kept over reset", rx_data, 8'hA5);
    chk("R9 fe cleared by reset", fe_flag, 0);
    chk("R9 rdf cleared by reset", rdf_flag, 0);
    chk("R9 rxip cleared by reset", rxip_flag, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule